// File: doc/BRIEF.md
# Receive Sync and Frame Delimiter Detector

This block watches the bit stream coming out of receive clock recovery and decides when a burst has really started. While the receive command is high it looks for a run of back-to-back copies of a programmable sync word. Once the required number of consecutive copies has been seen, it reports sync and then looks for a programmable frame delimiter. When the delimiter is found it reports the frame and marks the first user-data bit with a one-cycle strobe.

A 16-bit time limit, counted in oversampling clocks, bounds the search. When the limit runs out before a delimiter is found, a sync-done flag is set and an active-low interrupt is raised. Noise or long-run indications from the channel analysis stop the sync search early. Dropping the receive command ends the reception and clears every status.

Top module: `rx_frame_sync`

## Requirements
- R1: The sync word has `cfg_sw_len`+1 bits (code 0 is treated as 2 bits). The word matches when the most recent received bits equal the low used bits of `cfg_sw_pat`. The highest used pattern bit is the oldest bit, so it is received first.
- R2: Sync is declared after `cfg_sw_count`+1 consecutive matching words (code 0 to 7 gives 1 to 8 words). After the first match, each further word must follow back to back on word boundaries.
- R3: If a completed word does not match during counting, the count returns to zero and the search slides again bit by bit.
- R4: `sync_found` rises on the edge that declares sync. `frame_found` rises on the edge that sees the delimiter. Both stay high while `rx_en` remains high, and `frame_found` is never high without `sync_found`.
- R5: The delimiter has `cfg_dl_len`+1 bits (code 0 is treated as 2 bits), with the same bit order as R1. Only bits received after the edge that declared sync take part. When `cfg_err_ok` is 0, an exact match is required.
- R6: When `cfg_err_ok` is 1, the delimiter is accepted with at most one differing bit among the used bits.
- R7: `data_start` is high for exactly one cycle per frame. It follows the edge that samples the first valid bit after the delimiter.
- R8: The timer is cleared on the edge where `rx_en` is first seen high. On the (`cfg_limit`+1)-th edge after that one, if no delimiter has been found, `sync_done` goes to 1 and `irq_n` goes to 0. Both then hold while `rx_en` stays high.
- R9: Once `frame_found` is set, the timer stops and `sync_done` is not raised.
- R10: If `noise_flag` or `long_flag` is high on an edge while sync is still being hunted, the search stops and no sync is declared for the rest of that reception.
- R11: On reset, and one edge after `rx_en` is seen low, `sync_found`, `frame_found`, `sync_done` and `data_start` are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive command; high while receiving |
| bit_in | input | 1 | Recovered serial bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| noise_flag | input | 1 | Noise seen on the channel |
| long_flag | input | 1 | Long run of equal bits seen |
| cfg_sw_len | input | 3 | Sync word length code |
| cfg_sw_pat | input | 8 | Sync word pattern |
| cfg_sw_count | input | 3 | Consecutive sync words needed, minus one |
| cfg_dl_len | input | 5 | Delimiter length code |
| cfg_dl_pat | input | 32 | Delimiter pattern |
| cfg_err_ok | input | 1 | Allow one bit error in the delimiter |
| cfg_limit | input | 16 | Sync time limit in clocks |
| sync_found | output | 1 | Sync achieved |
| frame_found | output | 1 | Delimiter recognised |
| sync_done | output | 1 | Time limit expired |
| irq_n | output | 1 | Interrupt, active low |
| data_start | output | 1 | One-cycle mark of the first user-data bit |

## Verification
Streams are built with a clean preamble and with a delimiter that has one flipped bit. The flipped-bit stream is run once with strict matching and once with tolerant matching, which separates the exact compare from the Hamming-distance compare. A further stream breaks the sync-word run with a bad word, so a counter that is not reset would lock earlier than a correct one. A single-word, 8-bit sync with a 2-bit delimiter exercises the widest sync word and the shortest delimiter. Directed runs cover the time limit with no input, a lock with no delimiter, the timer freezing after a frame, and a noise abort that blocks a later valid preamble.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HUNT  = 3'd1,
    S_DELIM = 3'd2,
    S_FRAME = 3'd3,
    S_HALT  = 3'd4
  } rfs_state_t;
endpackage

// File: rtl/rfs_window_match.sv
module rfs_window_match #(
  parameter int W  = 8,
  parameter int LW = 3,
  parameter int EW = 4
) (
  input  logic [W-1:0]  win,
  input  logic [W-1:0]  pat,
  input  logic [LW-1:0] len_code,
  output logic [EW-1:0] nbits,
  output logic [EW-1:0] errs
);
  logic [W-1:0] diff;

  always_comb begin
    if (len_code == '0) nbits = EW'(2);
    else                nbits = EW'(len_code) + EW'(1);
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign diff[i] = (win[i] ^ pat[i]) && (EW'(i) < nbits);
    end
  endgenerate

  always_comb begin
    errs = '0;
    for (int k = 0; k < W; k++) errs = errs + EW'(diff[k]);
  end
endmodule

// File: rtl/rfs_hunt.sv
module rfs_hunt #(
  parameter int NCW = 3,
  parameter int SWE = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           hit,
  input  logic [SWE-1:0] word_len,
  input  logic [NCW-1:0] need,
  output logic           lock
);
  logic [NCW-1:0] got;
  logic [SWE-1:0] bcnt;
  logic           word_end;

  assign word_end = (bcnt == word_len - SWE'(1));

  always_comb begin
    lock = 1'b0;
    if (step && hit) begin
      if (got == '0) lock = (need == '0);
      else           lock = word_end && (got == need);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      got  <= '0;
      bcnt <= '0;
    end else if (step) begin
      if (got == '0) begin
        if (hit) begin
          got  <= NCW'(1);
          bcnt <= '0;
        end
      end else if (word_end) begin
        bcnt <= '0;
        if (hit) got <= got + NCW'(1);
        else     got <= '0;
      end else begin
        bcnt <= bcnt + SWE'(1);
      end
    end
  end

  // R3: a failed word boundary drops the run count
  a_r3_miss_resets: assert property (@(posedge clk) disable iff (rst)
    (step && got != '0 && word_end && !hit) |=> (got == '0));
endmodule

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt <= '0;
    else if (en && !expire) cnt <= cnt + TW'(1);
  end

  // R9: the count is frozen whenever counting is not enabled
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rx_frame_sync.sv
module rx_frame_sync
  import rfs_pkg::*;
#(
  parameter int SW_MAX = 8,
  parameter int DL_MAX = 32,
  parameter int NCW    = 3,
  parameter int TW     = 16,
  localparam int SWL   = $clog2(SW_MAX),
  localparam int DLL   = $clog2(DL_MAX),
  localparam int SWE   = $clog2(SW_MAX + 1),
  localparam int DLE   = $clog2(DL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              noise_flag,
  input  logic              long_flag,
  input  logic [SWL-1:0]    cfg_sw_len,
  input  logic [SW_MAX-1:0] cfg_sw_pat,
  input  logic [NCW-1:0]    cfg_sw_count,
  input  logic [DLL-1:0]    cfg_dl_len,
  input  logic [DL_MAX-1:0] cfg_dl_pat,
  input  logic              cfg_err_ok,
  input  logic [TW-1:0]     cfg_limit,
  output logic              sync_found,
  output logic              frame_found,
  output logic              sync_done,
  output logic              irq_n,
  output logic              data_start
);
  rfs_state_t        state;
  logic [DL_MAX-1:0] hist, nxt_hist;
  logic [DLE-1:0]    seen, seen_inc;
  logic              armed;
  logic              sync_q, frame_q, done_q, irq_q, start_q;

  logic [SWE-1:0] sw_nbits, sw_errs;
  logic [DLE-1:0] dl_nbits, dl_errs;
  logic           sw_hit, dl_ok, lock, expire, tmr_en, tmr_clr, hunt_step;

  assign nxt_hist = {hist[DL_MAX-2:0], bit_in};
  assign seen_inc = (seen == DLE'(DL_MAX)) ? seen : seen + DLE'(1);

  rfs_window_match #(.W(SW_MAX), .LW(SWL), .EW(SWE)) i_sw_match (
    .win(nxt_hist[SW_MAX-1:0]), .pat(cfg_sw_pat), .len_code(cfg_sw_len),
    .nbits(sw_nbits), .errs(sw_errs));

  rfs_window_match #(.W(DL_MAX), .LW(DLL), .EW(DLE)) i_dl_match (
    .win(nxt_hist), .pat(cfg_dl_pat), .len_code(cfg_dl_len),
    .nbits(dl_nbits), .errs(dl_errs));

  assign sw_hit    = (sw_errs == '0);
  assign dl_ok     = (seen_inc >= dl_nbits) &&
                     (dl_errs <= (cfg_err_ok ? DLE'(1) : DLE'(0)));
  assign hunt_step = rx_en && bit_vld && (state == S_HUNT);

  rfs_hunt #(.NCW(NCW), .SWE(SWE)) i_hunt (
    .clk(clk), .rst(rst), .clr(state != S_HUNT || !rx_en),
    .step(hunt_step), .hit(sw_hit), .word_len(sw_nbits),
    .need(cfg_sw_count), .lock(lock));

  assign tmr_clr = !rx_en || (state == S_IDLE);
  assign tmr_en  = rx_en && !done_q &&
                   (state == S_HUNT || state == S_DELIM || state == S_HALT);

  rfs_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .limit(cfg_limit), .expire(expire));

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      state   <= S_IDLE;
      hist    <= '0;
      seen    <= '0;
      armed   <= 1'b0;
      sync_q  <= 1'b0;
      frame_q <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (bit_vld && state != S_IDLE) hist <= nxt_hist;
      if (expire) begin
        done_q <= 1'b1;
        irq_q  <= 1'b0;
      end
      case (state)
        S_IDLE: state <= S_HUNT;
        S_HUNT: begin
          if (expire || noise_flag || long_flag) begin
            state <= S_HALT;
          end else if (lock) begin
            state  <= S_DELIM;
            sync_q <= 1'b1;
            seen   <= '0;
          end
        end
        S_DELIM: begin
          if (expire) begin
            state <= S_HALT;
          end else if (bit_vld) begin
            seen <= seen_inc;
            if (dl_ok) begin
              state   <= S_FRAME;
              frame_q <= 1'b1;
              armed   <= 1'b1;
            end
          end
        end
        S_FRAME: begin
          if (armed && bit_vld) begin
            start_q <= 1'b1;
            armed   <= 1'b0;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign sync_found  = sync_q;
  assign frame_found = frame_q;
  assign sync_done   = done_q;
  assign irq_n       = irq_q;
  assign data_start  = start_q;

  // R4: frame status only with sync status
  a_r4_frame_needs_sync: assert property (@(posedge clk) disable iff (rst)
    frame_q |-> sync_q);
  // R4: sync status holds while receiving
  a_r4_sync_holds: assert property (@(posedge clk) disable iff (rst)
    (sync_q && rx_en) |=> sync_q);
  // R7: data-start strobe lasts a single cycle
  a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R8: sync-done holds while receiving
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_q && rx_en) |=> (done_q && !irq_q));
  // R9: no timeout once a frame is seen
  a_r9_no_done_after_frame: assert property (@(posedge clk) disable iff (rst)
    frame_q |-> !done_q);
  // R11: dropping the receive command clears all status
  a_r11_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!sync_q && !frame_q && !done_q && irq_q && !start_q));
endmodule

// File: tb/test_rx_frame_sync.sv
module test_rx_frame_sync;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  swc;
    logic [7:0]  swp;
    logic [2:0]  need;
    logic [4:0]  dlc;
    logic [31:0] dlp;
    logic        eok;
    logic [63:0] bits;
    logic [7:0]  nb;
    logic        es;
    logic        ef;
    logic [7:0]  est;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 8'h0A, 3'd1, 5'd7, 32'hC3, 1'b0, 64'hAAC3_6000_0000_0000, 8'd20, 1'b1, 1'b1, 8'd16},
    '{3'd3, 8'h0A, 3'd1, 5'd7, 32'hC3, 1'b0, 64'hAAC7_6000_0000_0000, 8'd20, 1'b1, 1'b0, 8'hFF},
    '{3'd3, 8'h0A, 3'd1, 5'd7, 32'hC3, 1'b1, 64'hAAC7_6000_0000_0000, 8'd20, 1'b1, 1'b1, 8'd16},
    '{3'd3, 8'h0A, 3'd2, 5'd7, 32'hC3, 1'b0, 64'hAAEA_AAC3_4000_0000, 8'd34, 1'b1, 1'b1, 8'd32},
    '{3'd7, 8'h96, 3'd0, 5'd1, 32'h01, 1'b0, 64'h9678_0000_0000_0000, 8'd13, 1'b1, 1'b1, 8'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic noise_flag = 1'b0, long_flag = 1'b0;
  logic [2:0]  cfg_sw_len = 3'd3;
  logic [7:0]  cfg_sw_pat = 8'h0A;
  logic [2:0]  cfg_sw_count = 3'd1;
  logic [4:0]  cfg_dl_len = 5'd7;
  logic [31:0] cfg_dl_pat = 32'hC3;
  logic        cfg_err_ok = 1'b0;
  logic [15:0] cfg_limit = 16'd1000;
  logic sync_found, frame_found, sync_done, irq_n, data_start;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_sync i_rx_frame_sync (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_in(bit_in), .bit_vld(bit_vld),
    .noise_flag(noise_flag), .long_flag(long_flag),
    .cfg_sw_len(cfg_sw_len), .cfg_sw_pat(cfg_sw_pat), .cfg_sw_count(cfg_sw_count),
    .cfg_dl_len(cfg_dl_len), .cfg_dl_pat(cfg_dl_pat), .cfg_err_ok(cfg_err_ok),
    .cfg_limit(cfg_limit), .sync_found(sync_found), .frame_found(frame_found),
    .sync_done(sync_done), .irq_n(irq_n), .data_start(data_start));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rx_en = 1'b0;
    bit_vld = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(posedge clk);
  endtask

  task automatic send(input logic [63:0] bits, input int nb,
                      output int pulses, output int sidx);
    pulses = 0;
    sidx = 255;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (data_start) begin pulses++; sidx = i - 1; end
      bit_in = bits[63 - i];
      bit_vld = 1'b1;
    end
    @(negedge clk);
    if (data_start) begin pulses++; sidx = nb - 1; end
    bit_vld = 1'b0;
    @(negedge clk);
    if (data_start) pulses++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pulses, sidx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset sync", {31'd0, sync_found}, 32'd0);
    chk("R11 reset frame", {31'd0, frame_found}, 32'd0);
    chk("R11 reset done", {31'd0, sync_done}, 32'd0);
    chk("R11 reset irq_n", {31'd0, irq_n}, 32'd1);
    chk("R11 reset start", {31'd0, data_start}, 32'd0);

    // Vector table: R1 R2 R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      cfg_sw_len = VECS[v].swc;
      cfg_sw_pat = VECS[v].swp;
      cfg_sw_count = VECS[v].need;
      cfg_dl_len = VECS[v].dlc;
      cfg_dl_pat = VECS[v].dlp;
      cfg_err_ok = VECS[v].eok;
      cfg_limit = 16'd1000;
      restart();
      send(VECS[v].bits, int'(VECS[v].nb), pulses, sidx);
      chk($sformatf("R1 R2 R3 R4 vec%0d sync", v), {31'd0, sync_found}, {31'd0, VECS[v].es});
      chk($sformatf("R5 R6 vec%0d frame", v), {31'd0, frame_found}, {31'd0, VECS[v].ef});
      chk($sformatf("R7 vec%0d start index", v), sidx, {24'd0, VECS[v].est});
      chk($sformatf("R7 vec%0d start pulses", v), pulses, VECS[v].ef ? 32'd1 : 32'd0);
    end

    // R9: timer stops after frame
    cfg_sw_len = 3'd3; cfg_sw_pat = 8'h0A; cfg_sw_count = 3'd1;
    cfg_dl_len = 5'd7; cfg_dl_pat = 32'hC3; cfg_err_ok = 1'b0;
    cfg_limit = 16'd30;
    restart();
    send(VECS[0].bits, 20, pulses, sidx);
    repeat (100) @(negedge clk);
    chk("R9 no done after frame", {31'd0, sync_done}, 32'd0);
    chk("R9 irq idle after frame", {31'd0, irq_n}, 32'd1);
    chk("R4 frame held", {31'd0, frame_found}, 32'd1);

    // R8: timeout with lock but no delimiter
    cfg_limit = 16'd40;
    restart();
    send(VECS[1].bits, 20, pulses, sidx);
    repeat (50) @(negedge clk);
    chk("R8 locked timeout done", {31'd0, sync_done}, 32'd1);
    chk("R4 sync held past timeout", {31'd0, sync_found}, 32'd1);

    // R8: exact expiry cycle with no input bits
    cfg_limit = 16'd20;
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (21) @(posedge clk);
    @(negedge clk);
    chk("R8 done not yet", {31'd0, sync_done}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 done at limit", {31'd0, sync_done}, 32'd1);
    chk("R8 irq low at limit", {31'd0, irq_n}, 32'd0);

    // R11: receive command low clears status
    rx_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 clear done", {31'd0, sync_done}, 32'd0);
    chk("R11 clear irq", {31'd0, irq_n}, 32'd1);

    // R10: noise stops the hunt, later preamble ignored
    cfg_limit = 16'd1000;
    rx_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    noise_flag = 1'b1;
    @(negedge clk);
    noise_flag = 1'b0;
    send(VECS[0].bits, 20, pulses, sidx);
    chk("R10 noise blocks sync", {31'd0, sync_found}, 32'd0);
    chk("R10 noise blocks frame", {31'd0, frame_found}, 32'd0);

    // R10: long-run flag does the same
    restart();
    @(negedge clk);
    long_flag = 1'b1;
    @(negedge clk);
    long_flag = 1'b0;
    send(VECS[0].bits, 20, pulses, sidx);
    chk("R10 long run blocks sync", {31'd0, sync_found}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule